// File: doc/BRIEF.md
# Memory range decoder register bank

This block keeps the software-visible configuration of a set of memory range decoders: four by default, each with a 64-bit base, a 64-bit size, a control word and a 64-bit list of interleave targets. Software reaches the registers through a plain 32-bit word port: a write strobe, a read strobe, a byte address and write data. A read returns its word one cycle later, flagged by `rvalid`. Each register keeps only the bits its write mask allows. A read-only capability word reports how many decoders the bank holds.

Setting the commit request bit in a decoder's control word marks that decoder committed. Clearing the bit in a later write to the same register uncommits it. The decoded base, size, control word (including the committed flag) and target list of every decoder go out on flat buses to an address router. The global control bits go out as well. Words above the decoder area are kept as plain 32-bit storage.

Top module: `memdec_reg_bank`

## Requirements
- R1: After reset every register reads 0, except the capability word at offset 0x00. That word reads 0x00000002: bits 3:0 hold the decoder-count code, and the other bits are zero. The code maps counts 1,2,4,6,8,10,12,14,16,20,24,28,32 to the values 0 through 0xC, and code 2 means 4 decoders. Every exported decoder bus is 0 after reset.
- R2: Writes to the capability word have no effect. It keeps reading 0x00000002.
- R3: The global control word at offset 0x04 keeps only bits 1:0 of a write (mask 0x3). Those two bits are exported on `glb_ctrl_o`.
- R4: Decoder n has its register group at byte offset 0x10 + 0x20*n. Base low and size low sit at +0x00 and +0x08, and keep only bits 31:28 of a write. Their lower bits always read 0. Base high (+0x04) and size high (+0x0C) keep all 32 bits.
- R5: The control word (+0x10) keeps only the bits in mask 0x13FF. Bit 10 is the read-only committed flag, and no write sets it directly.
- R6: A control write with bit 9 (commit request) set makes bit 10 read 1 from the next cycle on. A control write with bit 9 clear makes bit 10 read 0. No other write changes bit 10, and no write changes the flag of another decoder.
- R7: Target list high (+0x18) keeps all 32 bits. Target list low (+0x14) keeps all 32 bits when the `IS_ENDPOINT` parameter is 0, and only bits 31:28 when it is 1.
- R8: The decoder groups are independent. A write to one decoder's register changes no register of any other decoder.
- R9: The words from 0x10 + 0x20*NUM_DEC onwards (0x90 by default) are `PLAIN_WORDS` plain 32-bit registers that keep every bit. Offsets 0x08, 0x0C and +0x1C of each group read 0 and ignore writes, as does any offset beyond the plain words.
- R10: A read strobe in one cycle gives `rvalid` high with the addressed word on `rdata` in the next cycle. `rvalid` is low in any cycle that does not follow a read strobe.
- R11: Decoder n's exported base, size and target list are {high, low} of its registers, and its exported control word is what a read of that register returns. Each reflects a write from the cycle after the write, and does not change in any cycle that follows no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| rd_en | input | 1 | Read strobe for the word at `addr` |
| addr | input | ADDR_W | Byte address of the word; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `rvalid` |
| rvalid | output | 1 | High the cycle after a read strobe |
| glb_ctrl_o | output | 2 | Global control bits |
| dec_base_o | output | 64*NUM_DEC | Decoder bases, decoder n in bits 64n+63:64n |
| dec_size_o | output | 64*NUM_DEC | Decoder sizes, same packing |
| dec_ctrl_o | output | 32*NUM_DEC | Decoder control words including committed flag |
| dec_tgt_o | output | 64*NUM_DEC | Decoder target lists, same packing |

## Verification
Writes of all-ones to every kind of register show each write mask directly, because the stored value equals the mask. A pattern whose bit 9 is clear but whose other bits are all ones shows that the committed flag follows only the commit request. Each decoder's base high gets a different value, and all four are then read back and compared on the exported buses. This shows whether the group stride and the decoder index decode are right. Back-to-back reads mixed with writes to reserved and unused offsets tell a lost or misordered read result apart from a write that landed where it should not.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned GRP_START = 16;
  localparam int unsigned GRP_BYTES = 32;
  localparam int unsigned NREG      = 7;

  typedef enum logic [2:0] {
    SUB_BASE_LO = 3'd0,
    SUB_BASE_HI = 3'd1,
    SUB_SIZE_LO = 3'd2,
    SUB_SIZE_HI = 3'd3,
    SUB_CTRL    = 3'd4,
    SUB_TGT_LO  = 3'd5,
    SUB_TGT_HI  = 3'd6,
    SUB_NONE    = 3'd7
  } sub_e;

  localparam logic [REG_W-1:0] MSK_GLB  = 32'h0000_0003;
  localparam logic [REG_W-1:0] MSK_TOP4 = 32'hF000_0000;
  localparam logic [REG_W-1:0] MSK_FULL = 32'hFFFF_FFFF;
  localparam logic [REG_W-1:0] MSK_CTRL = 32'h0000_13FF;
  localparam int unsigned BIT_COMMIT    = 9;
  localparam int unsigned BIT_COMMITTED = 10;

  // nonlinear decoder-count code of the capability word
  function automatic logic [3:0] count_code(input int unsigned n);
    logic [3:0] c;
    case (n)
      1:  c = 4'h0;
      2:  c = 4'h1;
      4:  c = 4'h2;
      6:  c = 4'h3;
      8:  c = 4'h4;
      10: c = 4'h5;
      12: c = 4'h6;
      14: c = 4'h7;
      16: c = 4'h8;
      20: c = 4'h9;
      24: c = 4'hA;
      28: c = 4'hB;
      32: c = 4'hC;
      default: c = 4'h0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/memdec_rst_sync.sv
module memdec_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/memdec_slot.sv
module memdec_slot
  import memdec_pkg::*;
#(
  parameter logic [31:0] TGT_LO_MSK = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  sub_e        wr_sub,
  input  logic [31:0] wdata,
  input  sub_e        rd_sub,
  output logic [31:0] rd_word,
  output logic [63:0] base_o,
  output logic [63:0] size_o,
  output logic [31:0] ctrl_o,
  output logic [63:0] tgt_o
);
  logic [31:0] regs_q [NREG];
  logic [31:0] regs_d [NREG];
  logic        committed_q, committed_d;
  logic [31:0] wmask;

  always_comb begin
    case (wr_sub)
      SUB_BASE_LO, SUB_SIZE_LO: wmask = MSK_TOP4;
      SUB_BASE_HI, SUB_SIZE_HI: wmask = MSK_FULL;
      SUB_CTRL:                 wmask = MSK_CTRL;
      SUB_TGT_LO:               wmask = TGT_LO_MSK;
      SUB_TGT_HI:               wmask = MSK_FULL;
      default:                  wmask = '0;
    endcase
  end

  always_comb begin
    for (int k = 0; k < NREG; k++) regs_d[k] = regs_q[k];
    committed_d = committed_q;
    if (wr_sub != SUB_NONE) begin
      regs_d[wr_sub] = (regs_q[wr_sub] & ~wmask) | (wdata & wmask);
      if (wr_sub == SUB_CTRL) committed_d = wdata[BIT_COMMIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) regs_q[k] <= '0;
      committed_q <= 1'b0;
    end else if (wr_en) begin
      for (int k = 0; k < NREG; k++) regs_q[k] <= regs_d[k];
      committed_q <= committed_d;
    end
  end

  always_comb begin
    ctrl_o = regs_q[SUB_CTRL];
    ctrl_o[BIT_COMMITTED] = committed_q;
  end

  always_comb begin
    rd_word = '0;
    if (rd_sub == SUB_CTRL)      rd_word = ctrl_o;
    else if (rd_sub != SUB_NONE) rd_word = regs_q[rd_sub];
  end

  assign base_o = {regs_q[SUB_BASE_HI], regs_q[SUB_BASE_LO]};
  assign size_o = {regs_q[SUB_SIZE_HI], regs_q[SUB_SIZE_LO]};
  assign tgt_o  = {regs_q[SUB_TGT_HI],  regs_q[SUB_TGT_LO]};

  // R6
  commit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sub == SUB_CTRL && wdata[BIT_COMMIT]) |=> ctrl_o[BIT_COMMITTED]);
  // R6
  commit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sub == SUB_CTRL && !wdata[BIT_COMMIT]) |=> !ctrl_o[BIT_COMMITTED]);
  // R4
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_o[27:0] == 28'd0) && (size_o[27:0] == 28'd0));
  // R11
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(base_o) && $stable(size_o) && $stable(tgt_o) && $stable(ctrl_o)));
endmodule

// File: rtl/memdec_reg_bank.sv
module memdec_reg_bank
  import memdec_pkg::*;
#(
  parameter int unsigned NUM_DEC     = 4,
  parameter int unsigned PLAIN_WORDS = 4,
  parameter int unsigned ADDR_W      = 8,
  parameter bit          IS_ENDPOINT = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  output logic                    rvalid,
  output logic [1:0]              glb_ctrl_o,
  output logic [64*NUM_DEC-1:0]   dec_base_o,
  output logic [64*NUM_DEC-1:0]   dec_size_o,
  output logic [32*NUM_DEC-1:0]   dec_ctrl_o,
  output logic [64*NUM_DEC-1:0]   dec_tgt_o
);
  localparam int unsigned IDX_W     = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1;
  localparam int unsigned PIDX_W    = (PLAIN_WORDS > 1) ? $clog2(PLAIN_WORDS) : 1;
  localparam int unsigned GRP_END   = GRP_START + NUM_DEC * GRP_BYTES;
  localparam int unsigned PLAIN_END = GRP_END + 4 * PLAIN_WORDS;
  localparam logic [ADDR_W-1:0] A_GLB    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_GRP_LO = ADDR_W'(GRP_START);
  localparam logic [ADDR_W-1:0] A_GRP_HI = ADDR_W'(GRP_END);
  localparam logic [ADDR_W-1:0] A_PL_HI  = ADDR_W'(PLAIN_END);
  localparam logic [31:0] CAP_VAL    = {28'd0, count_code(NUM_DEC)};
  localparam logic [31:0] TGT_LO_MSK = IS_ENDPOINT ? MSK_TOP4 : MSK_FULL;

  logic              rst_sync_n;
  logic [ADDR_W-1:0] addr_w, grp_off, plain_off;
  logic              hit_cap, hit_glb, hit_grp, hit_plain;
  logic [IDX_W-1:0]  grp_idx;
  logic [PIDX_W-1:0] plain_idx;
  sub_e              grp_sub;
  logic [1:0]        glb_q, glb_d;
  logic [31:0]       plain_q [PLAIN_WORDS];
  logic [31:0]       plain_d [PLAIN_WORDS];
  logic [31:0]       slot_rd [NUM_DEC];
  logic [31:0]       rd_word, rdata_q;
  logic              rvalid_q;

  memdec_rst_sync u_rst_sync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // address decode
  always_comb begin
    addr_w    = {addr[ADDR_W-1:2], 2'b00};
    grp_off   = addr_w - A_GRP_LO;
    plain_off = addr_w - A_GRP_HI;
    hit_cap   = (addr_w == '0);
    hit_glb   = (addr_w == A_GLB);
    hit_grp   = (addr_w >= A_GRP_LO) && (addr_w < A_GRP_HI);
    hit_plain = (addr_w >= A_GRP_HI) && (addr_w < A_PL_HI);
    grp_idx   = grp_off[IDX_W+4:5];
    grp_sub   = sub_e'(grp_off[4:2]);
    plain_idx = plain_off[PIDX_W+1:2];
  end

  // decoder groups
  for (genvar g = 0; g < NUM_DEC; g++) begin : g_slot
    logic sel;
    assign sel = hit_grp && (grp_idx == IDX_W'(g));
    memdec_slot #(.TGT_LO_MSK(TGT_LO_MSK)) u_slot (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .wr_en  (wr_en && sel),
      .wr_sub (sel ? grp_sub : SUB_NONE),
      .wdata  (wdata),
      .rd_sub (sel ? grp_sub : SUB_NONE),
      .rd_word(slot_rd[g]),
      .base_o (dec_base_o[64*g +: 64]),
      .size_o (dec_size_o[64*g +: 64]),
      .ctrl_o (dec_ctrl_o[32*g +: 32]),
      .tgt_o  (dec_tgt_o[64*g +: 64])
    );
  end

  // global control and plain words: next state
  always_comb begin
    glb_d = glb_q;
    for (int k = 0; k < PLAIN_WORDS; k++) plain_d[k] = plain_q[k];
    if (hit_glb) glb_d = wdata[1:0] & MSK_GLB[1:0];
    if (hit_plain) plain_d[plain_idx] = wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      glb_q <= '0;
      for (int k = 0; k < PLAIN_WORDS; k++) plain_q[k] <= '0;
    end else if (wr_en) begin
      glb_q <= glb_d;
      for (int k = 0; k < PLAIN_WORDS; k++) plain_q[k] <= plain_d[k];
    end
  end

  // read mux
  always_comb begin
    rd_word = '0;
    if (hit_cap)   rd_word = CAP_VAL;
    if (hit_glb)   rd_word = {30'd0, glb_q};
    if (hit_plain) rd_word = plain_q[plain_idx];
    if (hit_grp)
      for (int k = 0; k < NUM_DEC; k++) rd_word = rd_word | slot_rd[k];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_word;
    end
  end

  assign rdata      = rdata_q;
  assign rvalid     = rvalid_q;
  assign glb_ctrl_o = glb_q;

  // R10
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_en |=> rvalid);
  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> !rvalid);
  // R2
  cap_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && hit_cap) |=> (rdata == CAP_VAL));
  // R3
  glb_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_en && hit_glb) |=> $stable(glb_ctrl_o));
endmodule

// File: tb/memdec_reg_bank_tb_top.sv
`timescale 1ns/100ps
module memdec_reg_bank_tb_top;
  localparam int unsigned ND = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [1:0]  glb_ctrl_o;
  logic [64*ND-1:0] dec_base_o, dec_size_o, dec_tgt_o;
  logic [32*ND-1:0] dec_ctrl_o;

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t sbq[$];
  exp_t cur;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  memdec_reg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .glb_ctrl_o(glb_ctrl_o),
    .dec_base_o(dec_base_o), .dec_size_o(dec_size_o),
    .dec_ctrl_o(dec_ctrl_o), .dec_tgt_o(dec_tgt_o));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    exp_t it;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = a;
    it.v = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  // monitor: pops expected read results as they appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (sbq.size() == 0) begin
        chk("R10 unexpected rvalid", 64'(rvalid), 64'd0);
      end else begin
        cur = sbq.pop_front();
        chk(cur.tag, 64'(rdata), 64'(cur.v));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 base export", dec_base_o, '0);
    chk("R1 ctrl export", 64'(dec_ctrl_o), 64'd0);
    rd(8'h00, 32'h0000_0002, "R1 capability");
    rd(8'h04, 32'h0, "R1 global");
    rd(8'h20, 32'h0, "R1 ctrl dec0");
    rd(8'h88, 32'h0, "R1 tgt hi dec3");
    rd(8'h90, 32'h0, "R1 plain");

    // R2 capability read-only
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h0000_0002, "R2 capability after write");

    // R3 global mask
    wr(8'h04, 32'hFFFF_FFFF);
    idle();
    chk("R3 glb export", 64'(glb_ctrl_o), 64'd3);
    rd(8'h04, 32'h3, "R3 global mask");

    // R4 base/size masks
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'h1234_5678);
    wr(8'h18, 32'h2ABC_DEF1);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h10, 32'hF000_0000, "R4 base lo");
    rd(8'h14, 32'h1234_5678, "R4 base hi");
    rd(8'h18, 32'h2000_0000, "R4 size lo");
    rd(8'h1C, 32'hFFFF_FFFF, "R4 size hi");
    idle();
    chk("R11 base export dec0", dec_base_o[63:0], 64'h1234_5678_F000_0000);
    chk("R11 size export dec0", dec_size_o[63:0], 64'hFFFF_FFFF_2000_0000);

    // R5 ctrl mask, commit bit clear
    wr(8'h40, 32'hFFFF_FDFF);
    rd(8'h40, 32'h0000_11FF, "R5 ctrl mask");

    // R6 commit and uncommit
    wr(8'h60, 32'h0000_0205);
    idle();
    chk("R6 committed next cycle", 64'(dec_ctrl_o[2*32 + 10]), 64'd1);
    chk("R6 other decoder untouched", 64'(dec_ctrl_o[10]), 64'd0);
    rd(8'h60, 32'h0000_0605, "R6 ctrl committed");
    wr(8'h60, 32'h0000_0005);
    rd(8'h60, 32'h0000_0005, "R6 ctrl uncommitted");

    // R7 target lists
    wr(8'h84, 32'hDEAD_BEEF);
    wr(8'h88, 32'hCAFE_F00D);
    rd(8'h84, 32'hDEAD_BEEF, "R7 tgt lo");
    rd(8'h88, 32'hCAFE_F00D, "R7 tgt hi");
    idle();
    chk("R11 tgt export dec3", dec_tgt_o[3*64 +: 64], 64'hCAFE_F00D_DEAD_BEEF);

    // R8 independent groups
    for (int i = 0; i < ND; i++) wr(8'(16 + 32*i + 4), 32'h100 + 32'(i));
    for (int i = 0; i < ND; i++) rd(8'(16 + 32*i + 4), 32'h100 + 32'(i), "R8 base hi per decoder");
    idle();
    for (int i = 0; i < ND; i++) chk("R8 base hi export", 64'(dec_base_o[64*i + 32 +: 32]), 64'h100 + 64'(i));
    rd(8'h30, 32'h0, "R8 dec1 base lo untouched");

    // R9 plain words and unused offsets
    wr(8'h94, 32'hA5A5_A5A5);
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'hC0, 32'hFFFF_FFFF);
    rd(8'h94, 32'hA5A5_A5A5, "R9 plain word");
    rd(8'h2C, 32'h0, "R9 unused group slot");
    rd(8'h08, 32'h0, "R9 reserved low word");
    rd(8'hC0, 32'h0, "R9 beyond plain");
    rd(8'h90, 32'h0, "R9 neighbour plain untouched");

    // R10 drain
    repeat (4) idle();
    chk("R10 rvalid idle", 64'(rvalid), 64'd0);
    chk("R10 scoreboard drained", 64'(sbq.size()), 64'd0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule